// File: doc/BRIEF.md
# T1 Frame Alignment Loss Monitor

This block supervises a T1 receive bit stream whose frame position has already been found. It counts valid bits to locate the framing bit of each frame, and counts frames to know where that bit sits inside the selected multiframe. Each framing bit that carries a known value is compared against the value it should have. A configurable error criterion decides when frame alignment has been lost, and a sticky flag reports it.

A host-visible error counter accumulates framing errors. It saturates at its maximum value and is cleared by a read-clear strobe. While auto-mode is enabled, the counter holds its value. A pulse on the sync-start input tells the block that a new alignment has been established. The next valid bit is then the framing bit of the first frame of a multiframe, and the loss state is cleared.

A frame is one framing bit followed by `SLOTS` time slots of `SLOT_BITS` bits each. The defaults give 193 bits per frame.

Top module: `t1_align_monitor`

## Requirements
- R1: Only cycles with `rx_valid` high advance the bit position. A frame is 1 + SLOTS*SLOT_BITS valid bits and its first bit is the framing bit. After a `sync_start` pulse, the next valid bit is the framing bit of frame 1 of the multiframe. Framing-bit checks follow that position.
- R2: With `fmt_sel` = 01 (12-frame), every frame is checked. Odd-numbered frames 1,3,…,11 expect 1,0,1,0,1,0. Even-numbered frames 2,4,…,12 expect 0,0,1,1,1,0.
- R3: With `fmt_sel` = 10 (24-frame extended superframe), only frames 4,8,12,16,20,24 are checked, against 0,0,1,0,1,1. The framing bits of all other frames have no effect on the flag or the counter.
- R4: With `fmt_sel` = 00 (4-frame) or 11 (72-frame), the framing bit of every frame is compared with `exp_fbit`, which is sampled in the same cycle.
- R5: With `crit_sel` = 00, `loss_flag` is set once 2 of the last 4 checked framing bits are wrong.
- R6: With `crit_sel` = 01 the window is 2 of the last 5. With `crit_sel` = 10 it is 2 of the last 6.
- R7: With `crit_sel` = 11, `loss_flag` is set when 4 consecutive extended-superframe multiframes each contain at least one wrong checked bit. A multiframe with no wrong checked bit restarts the run. In the other formats this criterion never sets the flag and never counts.
- R8: `loss_flag` stays set until `sync_start` is pulsed. The pulse clears the flag, the error window and the multiframe run.
- R9: `err_count` rises by one for each wrong checked framing bit when `crit_sel` is 00–10. It rises by one for each errored multiframe when `crit_sel` is 11. It saturates at all-ones.
- R10: While `auto_en` is high, `err_count` does not change, except when it is cleared.
- R11: `cnt_rd_clr` high clears `err_count` to 0 at the next edge. The clear takes precedence over an increment in the same cycle.
- R12: After reset, `loss_flag` is 0 and `err_count` is 0.
- R13: A framing bit sampled at clock edge k updates `loss_flag` and `err_count` at edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_bit | input | 1 | Received serial bit |
| rx_valid | input | 1 | Qualifies `rx_bit` |
| sync_start | input | 1 | New alignment pulse; restarts position and clears loss state |
| fmt_sel | input | 2 | Multiframe format: 00 4-frame, 01 12-frame, 10 extended superframe, 11 72-frame |
| crit_sel | input | 2 | Loss criterion: 00 2/4, 01 2/5, 10 2/6, 11 four bad superframes |
| auto_en | input | 1 | Freezes the error counter |
| exp_fbit | input | 1 | Expected framing bit for the 4- and 72-frame formats |
| cnt_rd_clr | input | 1 | Clears the error counter |
| loss_flag | output | 1 | Loss of frame alignment, sticky |
| err_count | output | CNT_W (16) | Saturating framing error count |

## Verification
A framing bit is registered by the check stage at the edge that samples it. The flag and the counter then follow one edge later, so each result is due two edges after its stimulus. Most checks send whole frames, idle for a few cycles, and only then sample, which keeps them clear of that delay. One directed test samples between the two edges to pin the delay down exactly: the count must still be unchanged after the first edge and must have moved after the second. Inputs change and outputs are read on the falling clock edge.

// File: rtl/t1am_pkg.sv
// Package: shared types and constants of the T1 frame alignment loss monitor.
// Assumes the format and criterion codes listed in the brief.
package t1am_pkg;

    // Multiframe format select codes
    typedef enum logic [1:0] {
        FMT_F4  = 2'd0,
        FMT_D4  = 2'd1,
        FMT_ESF = 2'd2,
        FMT_F72 = 2'd3
    } fmt_e;

    // Loss criterion select codes
    typedef enum logic [1:0] {
        CRIT_W4   = 2'd0,
        CRIT_W5   = 2'd1,
        CRIT_W6   = 2'd2,
        CRIT_ESF4 = 2'd3
    } crit_e;

    // Width of the frame-in-multiframe index (longest multiframe is 72)
    localparam int FIDX_W = 7;

    // Expected sequences, entry k in bit k (upper bits unused)
    localparam logic [7:0] D4_SIG_SEQ  = 8'b0001_1100;
    localparam logic [7:0] ESF_FAS_SEQ = 8'b0011_0100;

    // Result of one framing-bit check, registered by the check stage
    typedef struct packed {
        logic vld;      // a checked framing bit was seen
        logic err;      // it was wrong
        logic mf_done;  // it closed an extended superframe
        logic mf_bad;   // that superframe held at least one error
    } chk_t;

    // Number of frames in a multiframe for a given format
    function automatic logic [FIDX_W-1:0] mf_len(input fmt_e f);
        case (f)
            FMT_F4:  return FIDX_W'(4);
            FMT_D4:  return FIDX_W'(12);
            FMT_ESF: return FIDX_W'(24);
            default: return FIDX_W'(72);
        endcase
    endfunction

endpackage

// File: rtl/t1am_position.sv
// Module: t1am_position
// Tracks the bit position inside a frame and the frame index inside the
// multiframe. Assumes the stream is already aligned: sync_start marks that
// the next valid bit is the framing bit of the first frame.
module t1am_position #(
    parameter int FRAME_LEN = 193
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rx_valid,
    input  logic                          sync_start,
    input  t1am_pkg::fmt_e                fmt,
    output logic                          is_fbit,
    output logic [t1am_pkg::FIDX_W-1:0]   frame_idx
);
    localparam int POS_W = $clog2(FRAME_LEN);
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(FRAME_LEN - 1);

    logic [POS_W-1:0]              bit_pos;
    logic [t1am_pkg::FIDX_W-1:0]   idx_last;

    // Last frame index of the selected multiframe
    always_comb idx_last = t1am_pkg::mf_len(fmt) - 1'b1;

    // Framing bit is the valid bit at position zero
    always_comb is_fbit = rx_valid && (bit_pos == '0) && !sync_start;

    // Advance bit and frame counters on each valid bit
    always_ff @(posedge clk) begin
        if (!rst_n || sync_start) begin
            bit_pos   <= '0;
            frame_idx <= '0;
        end else if (rx_valid) begin
            if (bit_pos == POS_LAST) begin
                bit_pos   <= '0;
                frame_idx <= (frame_idx >= idx_last) ? '0 : frame_idx + 1'b1;
            end else begin
                bit_pos <= bit_pos + 1'b1;
            end
        end
    end

endmodule

// File: rtl/t1am_fbit_check.sv
// Module: t1am_fbit_check
// Compares each framing bit with the value the selected format expects and
// registers the outcome. Also gathers the per-superframe error summary.
// Assumes frame_idx is inside the selected multiframe.
module t1am_fbit_check (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          sync_start,
    input  logic                          is_fbit,
    input  logic                          rx_bit,
    input  logic                          exp_fbit,
    input  t1am_pkg::fmt_e                fmt,
    input  logic [t1am_pkg::FIDX_W-1:0]   frame_idx,
    output t1am_pkg::chk_t                chk
);
    import t1am_pkg::*;

    logic       checked;
    logic       expect_bit;
    logic       mf_last;
    logic [2:0] seq_k;
    logic       bit_err;
    logic       mf_acc;

    // Select the expected value and whether this frame is checked
    always_comb begin
        checked    = 1'b1;
        expect_bit = exp_fbit;
        mf_last    = 1'b0;
        seq_k      = '0;
        case (fmt)
            FMT_D4: begin
                seq_k      = frame_idx[3:1];
                expect_bit = frame_idx[0] ? D4_SIG_SEQ[seq_k] : ~seq_k[0];
            end
            FMT_ESF: begin
                seq_k      = frame_idx[4:2];
                checked    = (frame_idx[1:0] == 2'b11);
                expect_bit = ESF_FAS_SEQ[seq_k];
                mf_last    = (frame_idx == FIDX_W'(23));
            end
            default: begin
                checked    = 1'b1;
                expect_bit = exp_fbit;
            end
        endcase
    end

    // Mismatch of a checked framing bit
    always_comb bit_err = is_fbit && checked && (rx_bit != expect_bit);

    // Register the check result and accumulate superframe errors
    always_ff @(posedge clk) begin
        if (!rst_n || sync_start) begin
            chk    <= '0;
            mf_acc <= 1'b0;
        end else begin
            chk.vld     <= is_fbit && checked;
            chk.err     <= bit_err;
            chk.mf_done <= is_fbit && checked && mf_last;
            chk.mf_bad  <= mf_acc || bit_err;
            if (is_fbit && checked && (fmt == FMT_ESF)) begin
                mf_acc <= mf_last ? 1'b0 : (mf_acc || bit_err);
            end
        end
    end

endmodule

// File: rtl/t1am_loss_decide.sv
// Module: t1am_loss_decide
// Applies the selected loss criterion: a sliding m-of-n window of checked
// framing bits, or a run of errored extended superframes. The flag is sticky
// until sync_start. Assumes one check result per cycle at most.
module t1am_loss_decide #(
    parameter int WIN_BASE   = 4,
    parameter int ERR_THRESH = 2,
    parameter int RUN_LIMIT  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_start,
    input  t1am_pkg::crit_e   crit,
    input  t1am_pkg::chk_t    chk,
    output logic              loss
);
    import t1am_pkg::*;

    localparam int WIN_MAX = WIN_BASE + 2;
    localparam int HIT_W   = $clog2(WIN_MAX + 1);
    localparam int RUN_W   = $clog2(RUN_LIMIT + 1);

    logic [WIN_MAX-1:0] win;
    logic [WIN_MAX-1:0] win_nx;
    logic [HIT_W-1:0]   hits;
    logic [RUN_W-1:0]   run;
    logic [RUN_W-1:0]   run_nx;
    logic               win_trip;
    logic               run_trip;

    // Window after shifting in the newest result
    always_comb win_nx = {win[WIN_MAX-2:0], chk.err};

    // Count errors inside the selected window length
    always_comb begin
        hits = '0;
        for (int i = 0; i < WIN_MAX; i++) begin
            if (i < WIN_BASE + int'(crit)) begin
                hits = hits + HIT_W'(win_nx[i]);
            end
        end
    end

    // Next superframe run value, held at the limit
    always_comb run_nx = (run == RUN_W'(RUN_LIMIT)) ? run : run + 1'b1;

    // Trip conditions of the two criteria
    always_comb begin
        win_trip = chk.vld && (crit != CRIT_ESF4) && (int'(hits) >= ERR_THRESH);
        run_trip = chk.mf_done && chk.mf_bad && (crit == CRIT_ESF4)
                   && (run_nx == RUN_W'(RUN_LIMIT));
    end

    // Update window, superframe run and sticky flag
    always_ff @(posedge clk) begin
        if (!rst_n || sync_start) begin
            win  <= '0;
            run  <= '0;
            loss <= 1'b0;
        end else begin
            if (chk.vld) begin
                win <= win_nx;
            end
            if (chk.mf_done) begin
                run <= chk.mf_bad ? run_nx : '0;
            end
            if (win_trip || run_trip) begin
                loss <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/t1am_err_counter.sv
// Module: t1am_err_counter
// Saturating framing error counter with a clear that wins over counting and
// a hold input that freezes it. Assumes inc is a one-cycle event.
module t1am_err_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             hold,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Clear, hold or count up to the ceiling
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (inc && !hold && (cnt != CNT_MAX)) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/t1_align_monitor.sv
// Module: t1_align_monitor
// Top of the T1 frame alignment loss monitor: locates framing bits, checks
// them against the selected multiframe format, decides loss of alignment and
// counts framing errors. Assumes an already aligned input stream.
module t1_align_monitor #(
    parameter int SLOTS      = 24,
    parameter int SLOT_BITS  = 8,
    parameter int CNT_W      = 16,
    parameter int WIN_BASE   = 4,
    parameter int ERR_THRESH = 2,
    parameter int RUN_LIMIT  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_bit,
    input  logic             rx_valid,
    input  logic             sync_start,
    input  logic [1:0]       fmt_sel,
    input  logic [1:0]       crit_sel,
    input  logic             auto_en,
    input  logic             exp_fbit,
    input  logic             cnt_rd_clr,
    output logic             loss_flag,
    output logic [CNT_W-1:0] err_count
);
    import t1am_pkg::*;

    localparam int FRAME_LEN = 1 + SLOTS * SLOT_BITS;

    fmt_e                fmt;
    crit_e               crit;
    logic                is_fbit;
    logic [FIDX_W-1:0]   frame_idx;
    chk_t                chk;
    logic                cnt_inc;

    // Decode the select inputs
    always_comb begin
        fmt  = fmt_e'(fmt_sel);
        crit = crit_e'(crit_sel);
    end

    // Count event depends on the criterion in force
    always_comb cnt_inc = (crit == CRIT_ESF4) ? (chk.mf_done && chk.mf_bad)
                                              : (chk.vld && chk.err);

    t1am_position #(
        .FRAME_LEN (FRAME_LEN)
    ) u_position (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_valid   (rx_valid),
        .sync_start (sync_start),
        .fmt        (fmt),
        .is_fbit    (is_fbit),
        .frame_idx  (frame_idx)
    );

    t1am_fbit_check u_check (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_start (sync_start),
        .is_fbit    (is_fbit),
        .rx_bit     (rx_bit),
        .exp_fbit   (exp_fbit),
        .fmt        (fmt),
        .frame_idx  (frame_idx),
        .chk        (chk)
    );

    t1am_loss_decide #(
        .WIN_BASE   (WIN_BASE),
        .ERR_THRESH (ERR_THRESH),
        .RUN_LIMIT  (RUN_LIMIT)
    ) u_decide (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_start (sync_start),
        .crit       (crit),
        .chk        (chk),
        .loss       (loss_flag)
    );

    t1am_err_counter #(
        .CNT_W (CNT_W)
    ) u_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (cnt_inc),
        .hold  (auto_en),
        .clr   (cnt_rd_clr),
        .cnt   (err_count)
    );

endmodule

// File: rtl/t1am_checker.sv
// Module: t1am_checker
// Concurrent assertions for t1_align_monitor, bound to every instance.
module t1am_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sync_start,
    input logic             cnt_rd_clr,
    input logic             auto_en,
    input logic             loss_flag,
    input logic             chk_vld,
    input logic [CNT_W-1:0] err_count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    assert_sticky_loss_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (loss_flag && !sync_start) |=> loss_flag);

    assert_sync_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sync_start |=> !loss_flag);

    // R5: a new loss always follows a registered framing-bit check
    assert_loss_has_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(loss_flag) |-> $past(chk_vld));

    assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_rd_clr |=> (err_count == $past(err_count))
                        || (err_count == $past(err_count) + 1'b1));

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_count == CNT_MAX && !cnt_rd_clr) |=> (err_count == CNT_MAX));

    assert_auto_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && !cnt_rd_clr) |=> $stable(err_count));

    assert_read_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_rd_clr |=> (err_count == '0));

endmodule

bind t1_align_monitor t1am_checker #(
    .CNT_W (CNT_W)
) u_t1am_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_start (sync_start),
    .cnt_rd_clr (cnt_rd_clr),
    .auto_en    (auto_en),
    .loss_flag  (loss_flag),
    .chk_vld    (chk.vld),
    .err_count  (err_count)
);

// File: tb/t1_align_monitor_bench.sv
// Bench for t1_align_monitor: vector table walked by one loop, then directed
// tests for reset, timing and corner cases. Short frames keep runs brief.
module t1_align_monitor_bench;

    localparam int CLK_PERIOD = 10;
    localparam int SLOTS      = 3;
    localparam int SLOT_BITS  = 8;
    localparam int CNT_W      = 5;
    localparam int FRAME      = 1 + SLOTS * SLOT_BITS;
    localparam int NV         = 15;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rx_bit = 1'b0;
    logic             rx_valid = 1'b0;
    logic             sync_start = 1'b0;
    logic [1:0]       fmt_sel = 2'd1;
    logic [1:0]       crit_sel = 2'd0;
    logic             auto_en = 1'b0;
    logic             exp_fbit = 1'b0;
    logic             cnt_rd_clr = 1'b0;
    logic             loss_flag;
    logic [CNT_W-1:0] err_count;

    int n_cmp = 0;
    int n_bad = 0;
    int fidx  = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    t1_align_monitor #(
        .SLOTS     (SLOTS),
        .SLOT_BITS (SLOT_BITS),
        .CNT_W     (CNT_W)
    ) u_t1_align_monitor (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_bit     (rx_bit),
        .rx_valid   (rx_valid),
        .sync_start (sync_start),
        .fmt_sel    (fmt_sel),
        .crit_sel   (crit_sel),
        .auto_en    (auto_en),
        .exp_fbit   (exp_fbit),
        .cnt_rd_clr (cnt_rd_clr),
        .loss_flag  (loss_flag),
        .err_count  (err_count)
    );

    typedef struct packed {
        logic        aut;
        logic [1:0]  fmt;
        logic [1:0]  crit;
        logic [6:0]  nfr;
        logic [31:0] mask;   // bit i corrupts the framing bit of frame i
        logic        eloss;
        logic [4:0]  ecnt;
    } vec_t;

    localparam vec_t VEC [NV] = '{
        '{1'b0, 2'd1, 2'd0, 7'd12, 32'h0000_0000, 1'b0, 5'd0},
        '{1'b0, 2'd1, 2'd0, 7'd12, 32'h0000_0009, 1'b1, 5'd2},
        '{1'b0, 2'd1, 2'd0, 7'd12, 32'h0000_0011, 1'b0, 5'd2},
        '{1'b0, 2'd1, 2'd1, 7'd12, 32'h0000_0011, 1'b1, 5'd2},
        '{1'b0, 2'd1, 2'd1, 7'd12, 32'h0000_0021, 1'b0, 5'd2},
        '{1'b0, 2'd1, 2'd2, 7'd12, 32'h0000_0021, 1'b1, 5'd2},
        '{1'b0, 2'd1, 2'd2, 7'd12, 32'h0000_0041, 1'b0, 5'd2},
        '{1'b0, 2'd2, 2'd0, 7'd24, 32'h0000_0037, 1'b0, 5'd0},
        '{1'b0, 2'd2, 2'd0, 7'd24, 32'h0000_0088, 1'b1, 5'd2},
        '{1'b0, 2'd0, 2'd0, 7'd8,  32'h0000_0006, 1'b1, 5'd2},
        '{1'b0, 2'd3, 2'd2, 7'd20, 32'h0000_8204, 1'b0, 5'd3},
        '{1'b0, 2'd1, 2'd3, 7'd12, 32'h0000_0003, 1'b0, 5'd0},
        '{1'b0, 2'd2, 2'd3, 7'd24, 32'h0000_0008, 1'b0, 5'd1},
        '{1'b1, 2'd1, 2'd0, 7'd12, 32'h0000_0003, 1'b1, 5'd0},
        '{1'b0, 2'd1, 2'd0, 7'd12, 32'h0000_0002, 1'b0, 5'd1}
    };

    string tags [NV] = '{"R1", "R5", "R5", "R6", "R6", "R6", "R6",
                         "R3", "R3", "R4", "R4", "R7", "R9", "R10", "R2"};

    // Frames per multiframe, from the format codes in the requirements
    function automatic int frames_of(input int f);
        case (f)
            0: return 4;
            1: return 12;
            2: return 24;
            default: return 72;
        endcase
    endfunction

    // Correct framing bit for frame number idx+1 of the given format
    function automatic logic good_fbit(input int f, input int idx, input logic ext);
        int k;
        case (f)
            1: begin
                k = idx / 2;
                if (idx % 2 == 0) return (k % 2 == 0);
                return (k == 2 || k == 3 || k == 4);
            end
            2: begin
                k = idx / 4;
                if (idx % 4 != 3) return 1'b0;
                return (k == 2 || k == 4 || k == 5);
            end
            default: return ext;
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // One frame: framing bit, then payload with a stall cycle inside
    task automatic send_frame(input logic ferr);
        @(negedge clk);
        rx_valid = 1'b1;
        exp_fbit = (fidx % 3 == 0);
        rx_bit   = good_fbit(int'(fmt_sel), fidx, exp_fbit) ^ ferr;
        for (int b = 1; b < FRAME; b++) begin
            @(negedge clk);
            if (b == 5) begin
                rx_valid = 1'b0;
                @(negedge clk);
            end
            rx_valid = 1'b1;
            rx_bit   = b[0] ^ b[2];
            exp_fbit = b[1];
        end
        fidx = (fidx + 1) % frames_of(int'(fmt_sel));
    endtask

    task automatic run_frames(input int n, input logic [127:0] m);
        for (int i = 0; i < n; i++) send_frame(m[i]);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        rx_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic do_sync();
        @(negedge clk);
        rx_valid   = 1'b0;
        sync_start = 1'b1;
        @(negedge clk);
        sync_start = 1'b0;
        fidx = 0;
    endtask

    task automatic do_clear();
        @(negedge clk);
        cnt_rd_clr = 1'b1;
        @(negedge clk);
        cnt_rd_clr = 1'b0;
    endtask

    task automatic setup(input logic [1:0] f, input logic [1:0] c);
        @(negedge clk);
        fmt_sel  = f;
        crit_sel = c;
        auto_en  = 1'b0;
        do_sync();
        do_clear();
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: outputs during and right after reset
        check("R12 loss in reset", int'(loss_flag), 0);
        check("R12 count in reset", int'(err_count), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12 loss after reset", int'(loss_flag), 0);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            fmt_sel  = VEC[v].fmt;
            crit_sel = VEC[v].crit;
            auto_en  = VEC[v].aut;
            do_sync();
            do_clear();
            run_frames(int'(VEC[v].nfr), {96'd0, VEC[v].mask});
            idle(3);
            check({tags[v], " loss"}, int'(loss_flag), int'(VEC[v].eloss));
            check({tags[v], " count"}, int'(err_count), int'(VEC[v].ecnt));
        end
        auto_en = 1'b0;

        // R13: result due one edge after the registered check
        setup(2'd1, 2'd0);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_bit   = 1'b0;            // frame 1 expects 1
        @(negedge clk);
        rx_bit = 1'b0;
        check("R13 count after first edge", int'(err_count), 0);
        @(negedge clk);
        check("R13 count after second edge", int'(err_count), 1);

        // R1: sync in mid-frame restarts the position
        setup(2'd1, 2'd0);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_bit   = 1'b1;
        repeat (10) @(negedge clk);
        do_sync();
        do_clear();
        run_frames(12, '0);
        idle(3);
        check("R1 count after resync", int'(err_count), 0);
        check("R1 loss after resync", int'(loss_flag), 0);

        // R7: four errored superframes in a row
        setup(2'd2, 2'd3);
        run_frames(72, (128'd1 << 3) | (128'd1 << 27) | (128'd1 << 51));
        idle(3);
        check("R7 loss after three", int'(loss_flag), 0);
        run_frames(24, 128'd1 << 3);
        idle(3);
        check("R7 loss after four", int'(loss_flag), 1);
        check("R9 superframe count", int'(err_count), 4);
        // R8: flag sticky over good frames, cleared by sync
        run_frames(24, '0);
        idle(3);
        check("R8 loss sticky", int'(loss_flag), 1);
        do_sync();
        check("R8 loss cleared by sync", int'(loss_flag), 0);

        // R7: a clean superframe restarts the run
        setup(2'd2, 2'd3);
        run_frames(120, (128'd1 << 3) | (128'd1 << 27) | (128'd1 << 51) | (128'd1 << 99));
        idle(3);
        check("R7 run restarted", int'(loss_flag), 0);
        check("R7 count", int'(err_count), 4);

        // R8: sync clears the window
        setup(2'd1, 2'd0);
        run_frames(12, 128'd1 << 11);
        do_sync();
        run_frames(4, 128'd1);
        idle(3);
        check("R8 window cleared", int'(loss_flag), 0);
        check("R9 count across sync", int'(err_count), 2);

        // R11: read-clear
        do_clear();
        check("R11 count cleared", int'(err_count), 0);

        // R9: saturation
        setup(2'd1, 2'd0);
        run_frames(40, '1);
        idle(3);
        check("R9 saturated count", int'(err_count), 31);
        check("R5 loss on all errors", int'(loss_flag), 1);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule